// File: doc/BRIEF.md
# Programmable Clock Divider with Gated Fanout

This block turns one input clock into a lower-rate clock and drives the result onto two matched outputs. A three-bit static select picks either the input clock unchanged or the input divided by 2, 4, 8 or 16. A synchronous divider counter runs on the input's rising edge. Its bits supply the divided clocks, so every divided output has a 50% duty cycle.

An active-high `run` input gates the outputs. When `run` is low, both outputs are forced low and, in the divided modes, the counter is held at zero. `run` is sampled on the falling edge of the input clock, so an output can only be switched on or off while the input is low. No pass-through pulse is ever cut short. A synchronous active-high `rst` puts the block in its off state: counter at zero and outputs low.

Top module: `clk_div_fanout`

## Requirements
- R1: The ratios offered are 1, 2, 4, 8 and 16. Over 64 input periods with `run` high, the output shows 64, 32, 16, 8 and 4 rising edges respectively.
- R2: Select decoding works as follows. When `sel[2]`=0, the output is pass-through whatever `sel[1:0]` holds. When `sel[2]`=1, `sel[1:0]` = 0, 1, 2, 3 gives divide by 2, 4, 8, 16 respectively.
- R3: After `rst`, both outputs are low. With `run`=1 and `sel`=3'b111, the block then runs as a divide-by-16.
- R4: While the registered enable is off, both outputs are 0. No rising edge appears on them, whatever `sel` does.
- R5: A change of `run` takes effect at the next falling edge of `clk_in`, not at once. A drop while the clock is high leaves the current high phase whole.
- R6: In the divided modes the counter is cleared while disabled. Counter bit k gives the divide-by-2^(k+1) clock. After enabling, the first rising edge of the divide-by-2^(k+1) output comes at the 2^k-th input rising edge.
- R7: In pass-through mode with the enable on, the output equals `clk_in`. It is low in the whole low phase of the input.
- R8: Both outputs carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to divide and fan out |
| rst | input | 1 | Synchronous active-high reset; clears counter and enable |
| run | input | 1 | Output enable, sampled on the falling edge of `clk_in`; low disables and clears the divider |
| sel | input | 3 | Ratio select (see R2) |
| clk_out | output | NUM_OUT (2) | Fanned-out selected clock |

## Verification
Divided outputs are counter bits, so they change in the delta right after a rising edge of `clk_in`. Pass-through follows the input level directly. An edge on `run` shows at the outputs only after the next falling edge. The bench keeps its own count of enabled rising edges and its own enable flag, which it latches on falling edges. It compares both outputs a quarter period after every edge, so each sample falls after the registers have settled and before the next edge can move them. Ratio checks count output rising edges over a window of exactly 64 input rising edges that starts just after the enabling falling edge.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int SEL_W = 3;
  localparam int DIV_STAGES = 4;
  localparam int TAP_W = $clog2(DIV_STAGES + 1);
  typedef logic [TAP_W-1:0] tap_t;

  // tap 0 = input clock, tap k = counter bit k-1 (divide by 2^k)
  function automatic tap_t sel_to_tap(input logic [SEL_W-1:0] s);
    if (!s[SEL_W-1]) return '0;
    return tap_t'(s[1:0]) + tap_t'(1);
  endfunction
endpackage

// File: rtl/cdiv_counter.sv
`timescale 1ns/1ps
module cdiv_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R6: while enabled the counter advances by exactly one per rising edge
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
  // R6: a disabled cycle leaves the counter at zero
  assert_cnt_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/cdiv_select.sv
`timescale 1ns/1ps
module cdiv_select import cdiv_pkg::*; #(
  parameter int W = DIV_STAGES
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clk_i,
  input  logic [W-1:0]     cnt_i,
  output logic             out_o
);
  localparam int NTAP = W + 1;
  logic [NTAP-1:0] taps;
  tap_t            tap;

  assign taps = {cnt_i, clk_i};
  assign tap  = sel_to_tap(sel_i);
  assign out_o = taps[tap];
endmodule

// File: rtl/cdiv_gate.sv
`timescale 1ns/1ps
module cdiv_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic src_i,
  output logic en_o,
  output logic gated_o
);
  logic en_q;

  // sampled while the clock goes low, so the AND below only switches in a low phase
  always_ff @(negedge clk_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= run_i;
  end

  assign en_o    = en_q;
  assign gated_o = src_i & en_q;
endmodule

// File: rtl/cdiv_fanout.sv
`timescale 1ns/1ps
module cdiv_fanout #(
  parameter int N = 2
) (
  input  logic         src_i,
  output logic [N-1:0] fan_o
);
  for (genvar i = 0; i < N; i++) begin : g_leg
    assign fan_o[i] = src_i;
  end
endmodule

// File: rtl/clk_div_fanout.sv
`timescale 1ns/1ps
module clk_div_fanout import cdiv_pkg::*; #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk_in,
  input  logic               rst,
  input  logic               run,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] clk_out
);
  logic [DIV_STAGES-1:0] cnt;
  logic                  en;
  logic                  picked;
  logic                  gated;

  cdiv_counter #(.W(DIV_STAGES)) u_cnt (
    .clk_i(clk_in), .rst_i(rst), .en_i(en), .cnt_o(cnt)
  );

  cdiv_select #(.W(DIV_STAGES)) u_sel (
    .sel_i(sel), .clk_i(clk_in), .cnt_i(cnt), .out_o(picked)
  );

  cdiv_gate u_gate (
    .clk_i(clk_in), .rst_i(rst), .run_i(run), .src_i(picked),
    .en_o(en), .gated_o(gated)
  );

  cdiv_fanout #(.N(NUM_OUT)) u_fan (
    .src_i(gated), .fan_o(clk_out)
  );

  // R4: disabled means every output is low
  assert_off_low_R4: assert property (@(posedge clk_in) disable iff (rst)
    !en |-> (clk_out == '0));
  // R7: in pass-through the outputs are low just before each rising edge
  assert_pass_low_R7: assert property (@(posedge clk_in) disable iff (rst)
    !sel[SEL_W-1] |-> (clk_out == '0));
endmodule

// File: tb/sim_clk_div_fanout.sv
`timescale 1ns/1ps
module sim_clk_div_fanout;
  localparam int NO = 2;
  logic          clk_in = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b1;
  logic [2:0]    sel = 3'b111;
  logic [NO-1:0] clk_out;

  int checks = 0, failures = 0, rises = 0;
  bit done = 0, mon_on = 0;
  bit m_en = 0;
  int m_cnt = 0;

  always #2.5 clk_in = ~clk_in;

  clk_div_fanout #(.NUM_OUT(NO)) u0 (
    .clk_in(clk_in), .rst(rst), .run(run), .sel(sel), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference behaviour from the requirements
  always @(negedge clk_in) m_en = rst ? 1'b0 : run;                     // R5
  always @(posedge clk_in) m_cnt = (rst || !m_en) ? 0 : (m_cnt + 1) % 16; // R6
  always @(posedge clk_out[0]) rises++;

  function automatic bit exp_out(input bit lvl);
    if (!m_en) return 1'b0;
    if (!sel[2]) return lvl;
    return bit'((m_cnt >> sel[1:0]) & 1);
  endfunction

  task automatic sample(input bit lvl);
    bit e;
    string tag;
    e = exp_out(lvl);
    tag = !m_en ? "R4" : (!sel[2] ? "R7" : "R6");
    check(clk_out[0] === e, tag, int'(clk_out[0]), int'(e));
    check(clk_out[1] === clk_out[0], "R8", int'(clk_out[1]), int'(clk_out[0]));
  endtask

  always @(posedge clk_in) begin #1.25; if (mon_on) sample(1'b1); end
  always @(negedge clk_in) begin #1.25; if (mon_on) sample(1'b0); end

  task automatic set_mode(input logic [2:0] s);
    @(posedge clk_in); #0.5 run = 1'b0;
    repeat (2) @(posedge clk_in);
    #0.5 sel = s;
    @(posedge clk_in); #0.5 run = 1'b1;
    @(negedge clk_in); #0.2 rises = 0;
  endtask

  task automatic measure(input logic [2:0] s, input int rexp);
    set_mode(s);
    repeat (64) @(posedge clk_in);
    #1;
    check(rises == rexp, s[2] ? "R1/R2 divide" : "R1/R2 pass", rises, rexp);
  endtask

  initial begin
    repeat (4) @(posedge clk_in);
    #0.5 rst = 1'b0;
    mon_on = 1;
    check(clk_out == '0, "R3 reset state", int'(clk_out), 0);
    @(negedge clk_in); #0.2 rises = 0;
    repeat (64) @(posedge clk_in);
    #1;
    check(rises == 4, "R3 default divide-by-16", rises, 4);

    for (int c = 0; c < 8; c++) begin
      logic [2:0] s;
      s = 3'(c);
      measure(s, s[2] ? (64 >> (int'(s[1:0]) + 1)) : 64);
    end

    // R5: disable and enable wait for a falling edge (pass-through)
    set_mode(3'b000);
    repeat (3) @(posedge clk_in);
    #0.5 run = 1'b0;
    #0.75 check(clk_out == 2'b11, "R5 drop while high keeps pulse", int'(clk_out), 3);
    @(negedge clk_in); #1.25 check(clk_out == 2'b00, "R5 off after falling edge", int'(clk_out), 0);
    @(posedge clk_in); #1.25 check(clk_out == 2'b00, "R5 stays off", int'(clk_out), 0);
    run = 1'b1;
    #0.5 check(clk_out == 2'b00, "R5 raise while high is deferred", int'(clk_out), 0);
    @(posedge clk_in); #1.25 check(clk_out == 2'b11, "R5 on after falling edge", int'(clk_out), 3);

    // R6: first divided edges after enable
    set_mode(3'b100);
    @(posedge clk_in); #1.25 check(clk_out == 2'b11, "R6 /2 first edge", int'(clk_out), 3);
    set_mode(3'b111);
    @(posedge clk_in); #1.25 check(clk_out == 2'b00, "R6 /16 after 1 edge", int'(clk_out), 0);
    repeat (6) @(posedge clk_in);
    #1.25 check(clk_out == 2'b00, "R6 /16 after 7 edges", int'(clk_out), 0);
    @(posedge clk_in); #1.25 check(clk_out == 2'b11, "R6 /16 after 8 edges", int'(clk_out), 3);
    set_mode(3'b101);
    repeat (5) @(posedge clk_in);
    set_mode(3'b101);
    @(posedge clk_in); #1.25 check(clk_out == 2'b00, "R6 /4 restart from zero", int'(clk_out), 0);
    @(posedge clk_in); #1.25 check(clk_out == 2'b11, "R6 /4 second edge", int'(clk_out), 3);

    // R4: disabled while select walks every code
    @(posedge clk_in); #0.5 run = 1'b0;
    @(negedge clk_in); #0.2 rises = 0;
    for (int c = 0; c < 8; c++) begin
      repeat (4) @(posedge clk_in);
      #0.5 sel = 3'(c);
    end
    repeat (2) @(posedge clk_in);
    #1 check(rises == 0, "R4 no edges while disabled", rises, 0);
    check(clk_out == '0, "R4 outputs low", int'(clk_out), 0);

    mon_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule